// File: doc/BRIEF.md
# Up/Down Auto-Reload Counter/Timer

This block is a 16-bit counter/timer that advances once per enabled count tick. The tick comes either from an internal enable strobe that runs on the system clock or from rising edges of an external count input. A 16-bit reload register holds the value that the counter restarts from. Counting up, the counter wraps from all ones to the reload value. Counting down, it wraps to all ones when the count reaches the reload value. Either kind of wrap sets a sticky wrap flag and toggles an extension bit, so the extension bit works as a seventeenth count bit.

An external control pin has one of two roles, chosen by a mode bit. It can be a reload trigger: a falling edge forces the counter to the reload value. Or it can be a live direction select, where a high level counts up and a low level counts down. Software uses a plain write port to load the counter and the reload register. It clears the wrap flag with a strobe. The interrupt request is the wrap flag masked by an enable input.

Top module: `updn_reload_timer`

## Requirements
- R1: The counter only advances on a tick while `run_en` is 1. With `run_en` at 0, no tick changes the count.
- R2: Counting up, a tick at 16'hFFFF loads the reload register into the counter and sets `wrap_flag_o`.
- R3: With `dir_mode` at 1, the synchronized `ext_ctl_i` level selects the direction: 1 counts up and 0 counts down. Edges on the pin then neither reload the counter nor set the flag.
- R4: With `ext_rld_en` at 1 and `dir_mode` at 0, a falling edge on `ext_ctl_i` loads the reload value exactly once. The reload happens on the third rising clock edge after the pin falls, and the flag is left unchanged. With `ext_rld_en` at 0 the edge has no effect.
- R5: Counting down, a tick while the count equals the reload value loads 16'hFFFF and sets `wrap_flag_o`.
- R6: `ext_bit_o` toggles on every up wrap and every down wrap and on nothing else. It never drives `irq_o`.
- R7: `irq_o` is 1 exactly when `wrap_flag_o` and `irq_en` are both 1.
- R8: With `src_sel` at 1, each rising edge of `ext_cnt_i` is one tick and `tick_i` is ignored. With `src_sel` at 0, `tick_i` is the tick.
- R9: When an external reload and an up wrap fall in the same cycle, the counter takes the reload value once, the flag is set and `ext_bit_o` toggles.
- R10: `wrap_flag_o` stays set until `flag_clr` is pulsed. If a wrap and `flag_clr` happen in the same cycle, the flag ends up set.
- R11: A write with `wr_cnt` loads `wr_data` into the counter and takes priority over any tick in that cycle, so no wrap is recorded. A write with `wr_rld` loads the reload register.
- R12: A synchronous active-high `rst` clears the counter, the reload register, the wrap flag and the extension bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Count enable |
| dir_mode | input | 1 | 1: external pin selects the direction; 0: counts up |
| ext_rld_en | input | 1 | Lets a falling edge on the external pin force a reload (only when `dir_mode` is 0) |
| src_sel | input | 1 | Count source: 0 internal tick, 1 external count input |
| tick_i | input | 1 | Internal count tick strobe |
| ext_cnt_i | input | 1 | Asynchronous external count input, counted on rising edges |
| ext_ctl_i | input | 1 | Asynchronous external control pin (reload trigger or direction) |
| irq_en | input | 1 | Interrupt enable |
| wr_cnt | input | 1 | Write strobe for the counter |
| wr_rld | input | 1 | Write strobe for the reload register |
| wr_data | input | 16 | Write data |
| flag_clr | input | 1 | Clear strobe for the wrap flag |
| cnt_o | output | 16 | Current count |
| rld_o | output | 16 | Reload register |
| wrap_flag_o | output | 1 | Sticky overflow/underflow flag |
| ext_bit_o | output | 1 | Extension bit that toggles on every wrap |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the mode inputs `dir_mode`, `src_sel` and `ext_rld_en` are changed only while the pin history in the synchronizer is quiet. Otherwise an edge that is still in flight would take on the new meaning. The stimulus therefore changes modes with `run_en` at 0 and then waits at least three clocks before the next pin edge or tick that matters. The stall property also assumes that nothing else moves the counter while it holds, so the bench keeps the external reload disabled, or the pin still, whenever it relies on a frozen count. External inputs are held for at least two clocks per level, so every edge is seen by the two-flop synchronizer.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } cnt_src_e;

    typedef enum logic [2:0] {
        NXT_HOLD,
        NXT_WRITE,
        NXT_RELOAD,
        NXT_TO_MAX,
        NXT_INC,
        NXT_DEC
    } cnt_next_e;

    // Per-cycle control decoded from the synchronized inputs
    typedef struct packed {
        logic tick;     // one count step this cycle
        logic up;       // direction of that step
        logic reload;   // forced reload from the external pin
    } tmr_ctl_t;

    function automatic logic fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

    function automatic logic rose(input logic prev, input logic cur);
        return ~prev & cur;
    endfunction

endpackage

// File: rtl/tmr_sync2.sv
module tmr_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] q_prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign q_o      = sync_q;
    assign q_prev_o = prev_q;
endmodule

// File: rtl/tmr_evt_ctl.sv
module tmr_evt_ctl
    import updn_tmr_pkg::*;
(
    input  logic     run_en,
    input  logic     dir_mode,
    input  logic     ext_rld_en,
    input  logic     src_sel,
    input  logic     tick_i,
    input  logic     pin_cur,
    input  logic     pin_prev,
    input  logic     ecnt_cur,
    input  logic     ecnt_prev,
    output tmr_ctl_t ctl_o
);
    logic raw_tick;

    always_comb begin
        if (cnt_src_e'(src_sel) == SRC_EXT) raw_tick = rose(ecnt_prev, ecnt_cur);
        else                                raw_tick = tick_i;

        ctl_o.tick   = run_en & raw_tick;
        ctl_o.up     = dir_mode ? pin_cur : 1'b1;
        ctl_o.reload = ext_rld_en & ~dir_mode & fell(pin_prev, pin_cur);
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctl_t         ctl,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic             flag_o,
    output logic             ext_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, rld_q, cnt_d;
    logic             flag_q, ext_q;
    logic             wrap;
    cnt_next_e        nxt;

    always_comb begin
        wrap = ctl.tick & ~wr_cnt &
               (ctl.up ? (cnt_q == ALL_ONES) : (cnt_q == rld_q));

        if (wr_cnt)                    nxt = NXT_WRITE;
        else if (ctl.reload)           nxt = NXT_RELOAD;
        else if (wrap && ctl.up)       nxt = NXT_RELOAD;
        else if (wrap)                 nxt = NXT_TO_MAX;
        else if (ctl.tick && ctl.up)   nxt = NXT_INC;
        else if (ctl.tick)             nxt = NXT_DEC;
        else                           nxt = NXT_HOLD;

        unique case (nxt)
            NXT_WRITE:  cnt_d = wr_data;
            NXT_RELOAD: cnt_d = rld_q;
            NXT_TO_MAX: cnt_d = ALL_ONES;
            NXT_INC:    cnt_d = cnt_q + ONE;
            NXT_DEC:    cnt_d = cnt_q - ONE;
            default:    cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            rld_q  <= '0;
            flag_q <= 1'b0;
            ext_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_rld) rld_q <= wr_data;
            if (wrap)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            if (wrap) ext_q <= ~ext_q;
        end
    end

    assign cnt_o  = cnt_q;
    assign rld_o  = rld_q;
    assign flag_o = flag_q;
    assign ext_o  = ext_q;
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             dir_mode,
    input  logic             ext_rld_en,
    input  logic             src_sel,
    input  logic             tick_i,
    input  logic             ext_cnt_i,
    input  logic             ext_ctl_i,
    input  logic             irq_en,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic             wrap_flag_o,
    output logic             ext_bit_o,
    output logic             irq_o
);
    localparam int N_SYNC = 2;
    localparam int PIN_B  = 0;
    localparam int ECNT_B = 1;

    logic [N_SYNC-1:0] async_in, sync_cur, sync_prev;
    tmr_ctl_t          ctl;

    assign async_in[PIN_B]  = ext_ctl_i;
    assign async_in[ECNT_B] = ext_cnt_i;

    tmr_sync2 #(.W(N_SYNC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .d_i      (async_in),
        .q_o      (sync_cur),
        .q_prev_o (sync_prev)
    );

    tmr_evt_ctl u_ctl (
        .run_en     (run_en),
        .dir_mode   (dir_mode),
        .ext_rld_en (ext_rld_en),
        .src_sel    (src_sel),
        .tick_i     (tick_i),
        .pin_cur    (sync_cur[PIN_B]),
        .pin_prev   (sync_prev[PIN_B]),
        .ecnt_cur   (sync_cur[ECNT_B]),
        .ecnt_prev  (sync_prev[ECNT_B]),
        .ctl_o      (ctl)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .wr_cnt   (wr_cnt),
        .wr_rld   (wr_rld),
        .wr_data  (wr_data),
        .flag_clr (flag_clr),
        .cnt_o    (cnt_o),
        .rld_o    (rld_o),
        .flag_o   (wrap_flag_o),
        .ext_o    (ext_bit_o)
    );

    assign irq_o = wrap_flag_o & irq_en;
endmodule

// File: rtl/updn_reload_timer_chk.sv
module updn_reload_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic             dir_mode,
    input logic             ext_rld_en,
    input logic             src_sel,
    input logic             tick_i,
    input logic             wr_cnt,
    input logic [CNT_W-1:0] wr_data,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cnt_o,
    input logic [CNT_W-1:0] rld_o,
    input logic             wrap_flag_o,
    input logic             ext_bit_o
);
    // R1
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !wr_cnt && !ext_rld_en) |=> $stable(cnt_o));

    // R2
    up_wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && tick_i && !src_sel && !dir_mode && !wr_cnt && (cnt_o == '1))
        |=> wrap_flag_o);

    // R6
    ext_bit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ext_bit_o) |-> wrap_flag_o);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_flag_o && !flag_clr) |=> wrap_flag_o);

    // R11
    sw_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt_o == $past(wr_data)));

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cnt_o == '0 && rld_o == '0 && !wrap_flag_o && !ext_bit_o));
endmodule

bind updn_reload_timer updn_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .run_en      (run_en),
    .dir_mode    (dir_mode),
    .ext_rld_en  (ext_rld_en),
    .src_sel     (src_sel),
    .tick_i      (tick_i),
    .wr_cnt      (wr_cnt),
    .wr_data     (wr_data),
    .flag_clr    (flag_clr),
    .cnt_o       (cnt_o),
    .rld_o       (rld_o),
    .wrap_flag_o (wrap_flag_o),
    .ext_bit_o   (ext_bit_o)
);

// File: tb/updn_reload_timer_bench.sv
module updn_reload_timer_bench;
    logic        clk = 1'b0;
    logic        rst, run_en, dir_mode, ext_rld_en, src_sel, tick_i;
    logic        ext_cnt_i, ext_ctl_i, irq_en, wr_cnt, wr_rld, flag_clr;
    logic [15:0] wr_data;
    logic [15:0] cnt_o, rld_o;
    logic        wrap_flag_o, ext_bit_o, irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        string       tag;
        logic [15:0] cnt;
        logic [15:0] rld;
        logic        flag;
        logic        ext;
        logic        irq;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    updn_reload_timer u_updn_reload_timer (
        .clk(clk), .rst(rst), .run_en(run_en), .dir_mode(dir_mode),
        .ext_rld_en(ext_rld_en), .src_sel(src_sel), .tick_i(tick_i),
        .ext_cnt_i(ext_cnt_i), .ext_ctl_i(ext_ctl_i), .irq_en(irq_en),
        .wr_cnt(wr_cnt), .wr_rld(wr_rld), .wr_data(wr_data), .flag_clr(flag_clr),
        .cnt_o(cnt_o), .rld_o(rld_o), .wrap_flag_o(wrap_flag_o),
        .ext_bit_o(ext_bit_o), .irq_o(irq_o)
    );

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() != 0);
            e = sb_q.pop_front();
            checks++;
            if (cnt_o !== e.cnt || rld_o !== e.rld || wrap_flag_o !== e.flag ||
                ext_bit_o !== e.ext || irq_o !== e.irq) begin
                fails++;
                $display("FAIL %s: got cnt=%h rld=%h flag=%b ext=%b irq=%b, expected cnt=%h rld=%h flag=%b ext=%b irq=%b",
                         e.tag, cnt_o, rld_o, wrap_flag_o, ext_bit_o, irq_o,
                         e.cnt, e.rld, e.flag, e.ext, e.irq);
            end
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic expect_now(input string tag, input logic [15:0] c, input logic [15:0] r,
                              input logic f, input logic x, input logic q);
        exp_t e;
        #1;
        e.tag = tag; e.cnt = c; e.rld = r; e.flag = f; e.ext = x; e.irq = q;
        sb_q.push_back(e);
        #1;
    endtask

    task automatic write_cnt(input logic [15:0] v);
        wr_cnt = 1'b1; wr_data = v; step(); wr_cnt = 1'b0;
    endtask

    task automatic write_rld(input logic [15:0] v);
        wr_rld = 1'b1; wr_data = v; step(); wr_rld = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; run_en = 0; dir_mode = 0; ext_rld_en = 0; src_sel = 0; tick_i = 0;
        ext_cnt_i = 0; ext_ctl_i = 0; irq_en = 0; wr_cnt = 0; wr_rld = 0;
        wr_data = '0; flag_clr = 0;
        step(2);
        expect_now("R12 reset state", 16'h0000, 16'h0000, 0, 0, 0);
        rst = 0;

        // R11 register writes
        write_rld(16'hFFF0);
        write_cnt(16'hFFFD);
        expect_now("R11 write ports", 16'hFFFD, 16'hFFF0, 0, 0, 0);

        // R2 / R6 up overflow reloads, sets flag, toggles extension bit
        run_en = 1; tick_i = 1;
        step(2);
        expect_now("R2 count to top", 16'hFFFF, 16'hFFF0, 0, 0, 0);
        step();
        expect_now("R2 R6 overflow reload", 16'hFFF0, 16'hFFF0, 1, 1, 0);

        // R7 interrupt gating
        irq_en = 1;
        expect_now("R7 irq enabled", 16'hFFF0, 16'hFFF0, 1, 1, 1);

        // R1 stall with run_en low
        run_en = 0;
        step(2);
        expect_now("R1 stalled", 16'hFFF0, 16'hFFF0, 1, 1, 1);

        // R10 clear and set-wins
        clear_flag();
        expect_now("R10 flag cleared", 16'hFFF0, 16'hFFF0, 0, 1, 0);
        write_cnt(16'hFFFF);
        run_en = 1; flag_clr = 1;
        step();
        run_en = 0; flag_clr = 0;
        expect_now("R10 set beats clear", 16'hFFF0, 16'hFFF0, 1, 0, 1);

        // R11 write beats a wrapping tick
        clear_flag();
        write_cnt(16'hFFFF);
        run_en = 1; wr_cnt = 1; wr_data = 16'h0100;
        step();
        wr_cnt = 0; run_en = 0;
        expect_now("R11 write priority", 16'h0100, 16'hFFF0, 0, 0, 0);

        // R5 down count with underflow at reload match
        write_rld(16'h0005);
        write_cnt(16'h0007);
        dir_mode = 1; ext_ctl_i = 0;
        step(3);
        run_en = 1;
        step(2);
        expect_now("R3 R5 count down", 16'h0005, 16'h0005, 0, 0, 0);
        step();
        expect_now("R5 R6 underflow", 16'hFFFF, 16'h0005, 1, 1, 1);
        step();
        run_en = 0;
        expect_now("R5 down after wrap", 16'hFFFE, 16'h0005, 1, 1, 1);

        // R3 pin high counts up; falling pin edge ignored in direction mode
        ext_rld_en = 1; ext_ctl_i = 1;
        step(3);
        run_en = 1;
        step(2);
        run_en = 0;
        expect_now("R3 pin high counts up", 16'h0005, 16'h0005, 1, 0, 1);
        clear_flag();
        write_rld(16'h0300);
        ext_ctl_i = 0;
        step(4);
        expect_now("R3 no reload in dir mode", 16'h0005, 16'h0300, 0, 0, 0);

        // R4 external reload on falling edge, exactly once
        dir_mode = 0; ext_ctl_i = 1;
        step(3);
        write_rld(16'hABCD);
        write_cnt(16'h1234);
        ext_ctl_i = 0;
        step(3);
        expect_now("R4 falling edge reload", 16'hABCD, 16'hABCD, 0, 0, 0);
        write_cnt(16'h0005);
        step(3);
        expect_now("R4 single reload pulse", 16'h0005, 16'hABCD, 0, 0, 0);

        // R4 edge ignored when external reload disabled
        ext_ctl_i = 1;
        step(3);
        ext_rld_en = 0; ext_ctl_i = 0;
        step(4);
        expect_now("R4 reload disabled", 16'h0005, 16'hABCD, 0, 0, 0);

        // R9 external reload coincides with overflow
        ext_rld_en = 1; ext_ctl_i = 1;
        step(3);
        write_rld(16'h2000);
        write_cnt(16'hFFFF);
        ext_ctl_i = 0;
        step(2);
        run_en = 1; tick_i = 1;
        step();
        run_en = 0;
        expect_now("R9 reload plus overflow", 16'h2000, 16'h2000, 1, 1, 1);

        // R8 external count source, internal tick ignored
        clear_flag();
        write_cnt(16'h0000);
        ext_rld_en = 0; src_sel = 1; tick_i = 1; run_en = 1;
        for (int p = 0; p < 4; p++) begin
            ext_cnt_i = 1; step(2);
            ext_cnt_i = 0; step(2);
        end
        step(3);
        run_en = 0;
        expect_now("R8 external count edges", 16'h0004, 16'h2000, 0, 1, 0);

        // R12 reset mid-operation
        rst = 1; src_sel = 0;
        step();
        expect_now("R12 reset clears all", 16'h0000, 16'h0000, 0, 0, 0);
        rst = 0;

        wait (sb_q.size() == 0);
        #1;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule